// File: doc/BRIEF.md
# Hiccup Soft-Start Sequencer

This block sequences the start-up of a voltage-mode switching regulator. It runs on the switching-rate clock. Once the bias supply is reported good and the block is enabled, it raises a digital reference clamp code from zero to full scale over a fixed number of switching cycles. The error amplifier reference follows the clamp, so the PWM pulses widen gradually. At the end of the ramp the block holds full scale and reports that it is regulating.

An overcurrent trip stops switching on the next clock edge. The block then enters hiccup mode. It runs a set number of internal ramp cycles with the output held off and starts a fresh output ramp after them. A fault that is still present at the retry sends the block back into hiccup, and this repeats with no limit. A low enable, a loss of bias-good or a synchronous reset returns the block to idle with switching inhibited.

Top module: `hiccup_softstart_seq`

## Requirements
- R1: When `rst_n` is sampled low, the next cycle shows `ref_code` = 0, `pwm_inhibit` = 1, `ramping` = 0 and `regulating` = 0 (idle).
- R2: In idle the block stays idle while `en` or `por_ok` is low.
- R3: The first edge in idle with `en` = 1 and `por_ok` = 1 starts a ramp. In the next cycle `ramping` = 1, `pwm_inhibit` = 0 and `ref_code` = 0.
- R4: In the cycle j cycles after a ramp starts, `ref_code` equals j * 2^CODE_W / RAMP_CYCLES (2*j with the defaults). It never decreases while `ramping` stays high.
- R5: A ramp lasts RAMP_CYCLES cycles (2048 by default). The block then reports `regulating` = 1, `pwm_inhibit` = 0 and `ref_code` at all ones (4095 by default).
- R6: When `oc_trip` is sampled high while ramping or regulating, the next cycle shows `pwm_inhibit` = 1, `ref_code` = 0 and both status flags low.
- R7: Hiccup lasts DELAY_RAMPS * RAMP_CYCLES cycles (6144 by default). A new ramp starting at code 0 follows on the next cycle.
- R8: `oc_trip` is ignored during hiccup. It neither restarts nor extends the delay.
- R9: When `oc_trip` stays high, each retry ramp trips again after one cycle, and the hiccup repeats without limit.
- R10: When `en` is sampled low, the block goes idle in the next cycle from any state. Setting `en` high again with bias good starts a new ramp.
- R11: When `por_ok` is sampled low, the block goes idle in the next cycle from any state.
- R12: `ramping` and `regulating` are never high together. `pwm_inhibit` is high exactly when neither flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Enable; low forces idle |
| por_ok | input | 1 | Bias supply above its power-on threshold |
| oc_trip | input | 1 | Overcurrent trip flag |
| ref_code | output | CODE_W | Reference clamp code |
| pwm_inhibit | output | 1 | High while switching must be off |
| ramping | output | 1 | Output soft-start ramp in progress |
| regulating | output | 1 | Ramp complete, full reference applied |

## Verification
Every output is decoded from registers updated at the edge that samples the inputs. A stimulus applied before an edge therefore shows at the outputs in the cycle that follows. Ramp codes fall due j cycles after the ramp start, and the hiccup exit falls due exactly 6144 cycles after the trip edge. The driver records each expected value together with the absolute cycle number in which it is due. The monitor compares it at the falling edge of that cycle. It also flags any expectation whose cycle has passed without a comparison. Because of this, a hiccup that is one cycle too long or too short, or that a trip during hiccup restarts, shows up as a mismatch at the boundary cycle.

// File: rtl/hsq_pkg.sv
package hsq_pkg;
   typedef enum logic [1:0] {
      HSQ_IDLE = 2'd0,
      HSQ_RAMP = 2'd1,
      HSQ_REG  = 2'd2,
      HSQ_HIC  = 2'd3
   } hsq_state_e;
endpackage

// File: rtl/hsq_cycle_timer.sv
module hsq_cycle_timer #(
   parameter int RAMP_CYCLES = 2048,
   parameter int DELAY_RAMPS = 3,
   localparam int CNT_W = $clog2(RAMP_CYCLES),
   localparam int DLY_W = (DELAY_RAMPS > 1) ? $clog2(DELAY_RAMPS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             run,
   output logic [CNT_W-1:0] cnt,
   output logic             ramp_end,
   output logic             delay_end
);
   logic [DLY_W-1:0] dly;

   assign ramp_end  = run && (cnt == CNT_W'(RAMP_CYCLES - 1));
   assign delay_end = ramp_end && (dly == DLY_W'(DELAY_RAMPS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         cnt <= '0;
         dly <= '0;
      end else if (run) begin
         cnt <= ramp_end ? '0 : cnt + 1'b1;
         if (ramp_end) dly <= dly + 1'b1;
      end
   end

   // ramp index never passes the last delay ramp
   assert_delay_index_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dly <= DLY_W'(DELAY_RAMPS - 1));
endmodule

// File: rtl/hsq_ctrl.sv
module hsq_ctrl #(
   parameter int RAMP_CYCLES = 2048,
   parameter int DELAY_RAMPS = 3,
   localparam int HIC_LEN = RAMP_CYCLES * DELAY_RAMPS,
   localparam int HL_W = $clog2(HIC_LEN) + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic                por_ok,
   input  logic                oc_trip,
   input  logic                ramp_end,
   input  logic                delay_end,
   output hsq_pkg::hsq_state_e st,
   output logic                timer_clear,
   output logic                timer_run
);
   import hsq_pkg::*;
   hsq_state_e st_q, nxt;

   always_comb begin
      nxt = st_q;
      if (!en || !por_ok) nxt = HSQ_IDLE;
      else begin
         unique case (st_q)
            HSQ_IDLE: nxt = HSQ_RAMP;
            HSQ_RAMP: if (oc_trip) nxt = HSQ_HIC; else if (ramp_end) nxt = HSQ_REG;
            HSQ_REG:  if (oc_trip) nxt = HSQ_HIC;
            HSQ_HIC:  if (delay_end) nxt = HSQ_RAMP;
            default:  nxt = HSQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= HSQ_IDLE;
      else        st_q <= nxt;
   end

   assign st          = st_q;
   assign timer_clear = (nxt != st_q);
   assign timer_run   = (st_q == HSQ_RAMP) || (st_q == HSQ_HIC);

   // checker state: cycles spent in the current hiccup
   logic [HL_W-1:0] hic_len;
   always_ff @(posedge clk) begin
      if (!rst_n || st_q != HSQ_HIC) hic_len <= '0;
      else                            hic_len <= hic_len + 1'b1;
   end

   assert_hiccup_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == HSQ_HIC && nxt == HSQ_RAMP) |-> hic_len == HL_W'(HIC_LEN - 1));
endmodule

// File: rtl/hsq_code_map.sv
module hsq_code_map #(
   parameter int CODE_W = 12,
   parameter int RAMP_CYCLES = 2048,
   localparam int CNT_W = $clog2(RAMP_CYCLES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  hsq_pkg::hsq_state_e st,
   input  logic [CNT_W-1:0]    cnt,
   output logic [CODE_W-1:0]   code
);
   import hsq_pkg::*;
   logic [CODE_W-1:0] scaled;
   logic              in_ramp;

   assign in_ramp = (st == HSQ_RAMP);

   generate
      if (CODE_W >= CNT_W) begin : g_widen
         assign scaled = CODE_W'(cnt) << (CODE_W - CNT_W);
         assert_code_rises_R4: assert property (@(posedge clk) disable iff (!rst_n)
            in_ramp |=> (!in_ramp || code > $past(code)));
      end else begin : g_narrow
         assign scaled = CODE_W'(cnt >> (CNT_W - CODE_W));
         assert_code_holds_or_rises_R4: assert property (@(posedge clk) disable iff (!rst_n)
            in_ramp |=> (!in_ramp || code >= $past(code)));
      end
   endgenerate

   always_comb begin
      unique case (st)
         HSQ_RAMP: code = scaled;
         HSQ_REG:  code = '1;
         default:  code = '0;
      endcase
   end
endmodule

// File: rtl/hiccup_softstart_seq.sv
module hiccup_softstart_seq #(
   parameter int CODE_W = 12,
   parameter int RAMP_CYCLES = 2048,
   parameter int DELAY_RAMPS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              por_ok,
   input  logic              oc_trip,
   output logic [CODE_W-1:0] ref_code,
   output logic              pwm_inhibit,
   output logic              ramping,
   output logic              regulating
);
   import hsq_pkg::*;
   localparam int CNT_W = $clog2(RAMP_CYCLES);

   generate
      if (RAMP_CYCLES < 2 || (RAMP_CYCLES & (RAMP_CYCLES - 1)) != 0) begin : g_bad_ramp
         $error("RAMP_CYCLES must be a power of two of at least 2");
      end
      if (DELAY_RAMPS < 1) begin : g_bad_delay
         $error("DELAY_RAMPS must be at least 1");
      end
      if (CODE_W < 1) begin : g_bad_code
         $error("CODE_W must be at least 1");
      end
   endgenerate

   hsq_state_e       st;
   logic [CNT_W-1:0] cnt;
   logic             ramp_end, delay_end, timer_clear, timer_run;

   hsq_ctrl #(.RAMP_CYCLES(RAMP_CYCLES), .DELAY_RAMPS(DELAY_RAMPS)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .en(en), .por_ok(por_ok), .oc_trip(oc_trip),
      .ramp_end(ramp_end), .delay_end(delay_end), .st(st),
      .timer_clear(timer_clear), .timer_run(timer_run));

   hsq_cycle_timer #(.RAMP_CYCLES(RAMP_CYCLES), .DELAY_RAMPS(DELAY_RAMPS)) timer_i (
      .clk(clk), .rst_n(rst_n), .clear(timer_clear), .run(timer_run),
      .cnt(cnt), .ramp_end(ramp_end), .delay_end(delay_end));

   hsq_code_map #(.CODE_W(CODE_W), .RAMP_CYCLES(RAMP_CYCLES)) map_i (
      .clk(clk), .rst_n(rst_n), .st(st), .cnt(cnt), .code(ref_code));

   assign ramping     = (st == HSQ_RAMP);
   assign regulating  = (st == HSQ_REG);
   assign pwm_inhibit = (st == HSQ_IDLE) || (st == HSQ_HIC);

   assert_trip_inhibits_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwm_inhibit && oc_trip && en && por_ok) |=> (pwm_inhibit && ref_code == '0));
   assert_full_code_when_regulating_R5: assert property (@(posedge clk) disable iff (!rst_n)
      regulating |-> ref_code == '1);
   assert_disable_goes_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (pwm_inhibit && !ramping && !regulating && ref_code == '0));
   assert_bias_loss_goes_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !por_ok |=> (pwm_inhibit && !ramping && !regulating));
   assert_flags_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ramping, regulating}) && (pwm_inhibit == !(ramping || regulating)));
endmodule

// File: tb/hiccup_softstart_seq_tb_top.sv
module hiccup_softstart_seq_tb_top;
   localparam int CODE_W = 12;
   localparam int RAMP = 2048;
   localparam int HIC = 3 * RAMP;
   localparam logic [CODE_W-1:0] FULL = '1;

   typedef struct {
      int                cyc;
      logic [CODE_W-1:0] code;
      bit                inh;
      bit                rmp;
      bit                rg;
      string             tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0, en = 1'b0, por_ok = 1'b0, oc_trip = 1'b0;
   logic [CODE_W-1:0] ref_code;
   logic pwm_inhibit, ramping, regulating;

   int cyc = 0;
   int checks = 0;
   int errors = 0;
   exp_t sb[$];

   always #4 clk = ~clk;

   hiccup_softstart_seq #(.CODE_W(CODE_W), .RAMP_CYCLES(RAMP), .DELAY_RAMPS(3)) dut_i (
      .clk(clk), .rst_n(rst_n), .en(en), .por_ok(por_ok), .oc_trip(oc_trip),
      .ref_code(ref_code), .pwm_inhibit(pwm_inhibit), .ramping(ramping),
      .regulating(regulating));

   always @(posedge clk) cyc <= cyc + 1;

   // driver side: queue an expectation for an absolute cycle
   task automatic expect_at(input int at, input int code, input bit inh,
                            input bit rmp, input bit rg, input string tag);
      exp_t e;
      e.cyc = at; e.code = CODE_W'(code); e.inh = inh; e.rmp = rmp; e.rg = rg; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: compare due items, flag missed ones, check flag coherence
   always @(negedge clk) begin
      for (int i = sb.size() - 1; i >= 0; i--) begin
         if (sb[i].cyc == cyc) begin
            checks++;
            if (ref_code !== sb[i].code || pwm_inhibit !== sb[i].inh ||
                ramping !== sb[i].rmp || regulating !== sb[i].rg) begin
               errors++;
               $display("FAIL %s cyc=%0d actual code=%0d inh=%0b rmp=%0b reg=%0b expected code=%0d inh=%0b rmp=%0b reg=%0b",
                        sb[i].tag, cyc, ref_code, pwm_inhibit, ramping, regulating,
                        sb[i].code, sb[i].inh, sb[i].rmp, sb[i].rg);
            end
            sb.delete(i);
         end else if (sb[i].cyc < cyc) begin
            checks++;
            errors++;
            $display("FAIL %s missed cyc=%0d actual none expected compare", sb[i].tag, sb[i].cyc);
            sb.delete(i);
         end
      end
      if (rst_n && cyc > 2) begin
         checks++;
         if ((ramping && regulating) || (pwm_inhibit !== !(ramping || regulating))) begin
            errors++;
            $display("FAIL R12 cyc=%0d actual inh=%0b rmp=%0b reg=%0b expected exclusive flags",
                     cyc, pwm_inhibit, ramping, regulating);
         end
      end
   end

   initial begin
      int t0;
      tick(3);
      expect_at(cyc + 1, 0, 1, 0, 0, "R1 reset state");
      tick(1);
      rst_n = 1'b1; en = 1'b1;
      expect_at(cyc + 1, 0, 1, 0, 0, "R2 waits for por_ok");
      expect_at(cyc + 5, 0, 1, 0, 0, "R2 still idle");
      tick(5);
      por_ok = 1'b1; t0 = cyc;
      expect_at(t0 + 1, 0, 0, 1, 0, "R3 ramp start");
      expect_at(t0 + 2, 2, 0, 1, 0, "R4 first step");
      expect_at(t0 + 1001, 2000, 0, 1, 0, "R4 mid ramp");
      expect_at(t0 + RAMP, 4094, 0, 1, 0, "R5 last ramp cycle");
      expect_at(t0 + RAMP + 1, FULL, 0, 0, 1, "R5 regulating");
      tick(RAMP + 50);

      // single trip while regulating, plus an ignored trip during hiccup
      oc_trip = 1'b1; t0 = cyc;
      expect_at(t0 + 1, 0, 1, 0, 0, "R6 trip from regulate");
      expect_at(t0 + 101, 0, 1, 0, 0, "R8 trip in hiccup ignored");
      expect_at(t0 + HIC, 0, 1, 0, 0, "R7 last hiccup cycle");
      expect_at(t0 + HIC + 1, 0, 0, 1, 0, "R7 retry ramp");
      expect_at(t0 + HIC + 2, 2, 0, 1, 0, "R8 exit not shifted");
      expect_at(t0 + HIC + 1 + RAMP, FULL, 0, 0, 1, "R7 back to regulate");
      tick(1); oc_trip = 1'b0;
      tick(99); oc_trip = 1'b1;
      tick(1); oc_trip = 1'b0;
      tick(HIC + RAMP);

      // persistent fault
      oc_trip = 1'b1; t0 = cyc;
      expect_at(t0 + 1, 0, 1, 0, 0, "R9 first trip");
      expect_at(t0 + HIC + 1, 0, 0, 1, 0, "R9 retry 1");
      expect_at(t0 + HIC + 2, 0, 1, 0, 0, "R9 trips again");
      expect_at(t0 + 2 * HIC + 1, 0, 1, 0, 0, "R9 second delay end");
      expect_at(t0 + 2 * HIC + 2, 0, 0, 1, 0, "R9 retry 2");
      expect_at(t0 + 2 * HIC + 502, 1000, 0, 1, 0, "R4 code at step 500");
      expect_at(t0 + 2 * HIC + 503, 0, 1, 0, 0, "R6 trip during ramp");
      tick(2 * HIC + 1); oc_trip = 1'b0;
      tick(501); oc_trip = 1'b1;
      tick(1); oc_trip = 1'b0;

      // enable drop during hiccup and re-enable
      tick(50); en = 1'b0; t0 = cyc;
      expect_at(t0 + 1, 0, 1, 0, 0, "R10 disable");
      tick(1); en = 1'b1;
      expect_at(t0 + 2, 0, 0, 1, 0, "R10 re-enable ramps");
      expect_at(t0 + 2 + RAMP, FULL, 0, 0, 1, "R10 regulate after re-enable");
      tick(RAMP + 10);

      // bias loss while regulating
      por_ok = 1'b0; t0 = cyc;
      expect_at(t0 + 1, 0, 1, 0, 0, "R11 bias loss");
      tick(1); por_ok = 1'b1;
      expect_at(t0 + 2, 0, 0, 1, 0, "R11 bias back ramps");
      tick(20);

      // reset during ramp
      rst_n = 1'b0; t0 = cyc;
      expect_at(t0 + 1, 0, 1, 0, 0, "R1 reset mid ramp");
      tick(2); rst_n = 1'b1;
      tick(5);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule